// File: doc/BRIEF.md
# Endpoint Handshake and Buffer Controller

This block makes the per-token decision for a single USB endpoint. It takes a decoded token and the status of the data packet that follows it, and chooses the reply: STALL, NAK, ACK, NYET, send data, or silence. It also keeps two buffer descriptors for the endpoint and moves between them as each buffer is filled or drained.

A descriptor records a byte pointer into the buffer memory, the number of bytes left, and a used flag. The controller rotates between the two buffers and skips any buffer that is unallocated, already used, or (for receive) too small for a full packet. When an OUT packet is accepted, or an IN packet is acknowledged, it advances the pointer and size of the active buffer. It marks the buffer used and raises a done event when the buffer is exhausted.

The surrounding logic serialises packets, checks CRCs and moves the bytes. This block only decides what happens and hands back the buffer, address and length to use.

Top module: `ep_hs_ctrl`

## Requirements
- R1: A descriptor word is {used[31], size[30:17], pointer[16:0]}. A pointer of all ones means unallocated. After reset both descriptors read used=0, size=0, pointer all ones. A load writes the whole word at the next clock edge.
- R2: On a non-control endpoint, the first buffer tried is buffer 0. The next token tries the current buffer first and the other buffer second. A buffer that is unallocated or has used=1 is skipped.
- R3: When a buffer completes, its used flag is set and buf_done pulses for one cycle with buf_done_sel naming it. The next token then starts at the other buffer. An OUT buffer completes when its remaining size drops below the max payload. An IN buffer completes when its size reaches 0.
- R4: If no buffer is usable, an IN token is answered NAK, and an OUT token is answered NAK in the cycle after the token, without waiting for data.
- R5: With halt set, IN, OUT and high-speed PING tokens are answered STALL.
- R6: An OUT data packet whose data PID differs from the expected toggle is answered ACK. The descriptor and the toggle stay unchanged.
- R7: An accepted OUT packet is answered ACK at full speed. At high speed it is answered NYET if the remaining size is then below the max payload, and ACK otherwise.
- R8: An OUT-side buffer is usable only if its size is at least the max payload. An IN reply sends the smaller of the max payload and the remaining size, starting at the buffer pointer.
- R9: After IN data, an ACK advances the pointer, reduces the size and flips the toggle. A timeout, or a new token arriving first, changes none of them.
- R10: On a control endpoint, SETUP, OUT and PING use buffer 0 only and IN uses buffer 1 only. A SETUP token resets the expected toggle to DATA0.
- R11: The data toggle (0 = DATA0, 1 = DATA1) flips only on an accepted OUT packet or an acknowledged IN packet.
- R12: An in-sequence OUT packet longer than the max payload or the remaining size is answered NAK and leaves the descriptor unchanged. A packet with a CRC error gets reply code NONE.
- R13: Reply code NONE is given, with no state change, for any token on a disabled endpoint, a PING at full speed, an IN token on an OUT endpoint, an OUT or PING on an IN endpoint, and a SETUP on a non-control endpoint.
- R14: A high-speed PING is answered ACK if a buffer with room for a max-size packet exists, and NAK otherwise. Token codes are OUT=0, IN=1, SETUP=2, PING=3. Reply codes are NONE=0, ACK=1, NAK=2, NYET=3, STALL=4, DATA=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token code |
| rx_valid | input | 1 | OUT/SETUP data packet finished |
| rx_crc_ok | input | 1 | Data packet CRC good |
| rx_pid | input | 1 | Data PID of the packet, 0 = DATA0 |
| rx_len | input | MPL_W | Payload bytes received |
| hs_valid | input | 1 | Host handshake outcome after IN data |
| hs_ack | input | 1 | 1 = ACK received, 0 = timeout or corrupt |
| cfg_ctrl | input | 1 | Control endpoint |
| cfg_dir_in | input | 1 | Non-control endpoint direction, 1 = IN |
| cfg_halt | input | 1 | Halt mode |
| cfg_disable | input | 1 | Endpoint disabled |
| cfg_hs | input | 1 | High-speed mode |
| cfg_max_pl | input | MPL_W | Max payload bytes |
| dsc_ld | input | 1 | Descriptor load strobe |
| dsc_ld_sel | input | 1 | Descriptor to load |
| dsc_ld_word | input | W | Descriptor value to load |
| rep_valid | output | 1 | Reply strobe |
| rep_code | output | 3 | Reply code |
| rep_sel | output | 1 | Buffer the reply concerns |
| rep_len | output | MPL_W | Bytes to send for a DATA reply |
| rep_ptr | output | PTR_W | Start address for a DATA reply |
| rep_pid | output | 1 | Data PID to send for a DATA reply |
| dsc0_word | output | W | Descriptor of buffer 0 |
| dsc1_word | output | W | Descriptor of buffer 1 |
| buf_done | output | 1 | A buffer completed |
| buf_done_sel | output | 1 | Which buffer completed |

## Verification
The bench uses the default widths: 14-bit size, 17-bit pointer, 11-bit payload. It sets the max payload to 64 bytes at the configuration pin, so each buffer boundary is reached in one or two packets. With these small buffers the bench can walk through a full rotation, the overflow case, the NYET boundary at high speed, and IN length clipping, all within a short run.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_PING  = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    RP_NONE  = 3'd0,
    RP_ACK   = 3'd1,
    RP_NAK   = 3'd2,
    RP_NYET  = 3'd3,
    RP_STALL = 3'd4,
    RP_DATA  = 3'd5
  } rep_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RXDATA = 2'd1,
    ST_TXACK  = 2'd2
  } ep_st_e;
endpackage

// File: rtl/ep_desc_bank.sv
module ep_desc_bank #(
  parameter int SIZE_W = 14,
  parameter int PTR_W  = 17
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ld_valid,
  input  logic                                ld_sel,
  input  logic [SIZE_W+PTR_W:0]               ld_word,
  input  logic                                upd_valid,
  input  logic                                upd_sel,
  input  logic [SIZE_W+PTR_W:0]               upd_word,
  output logic [1:0][SIZE_W+PTR_W:0]          words
);
  localparam int W = 1 + SIZE_W + PTR_W;
  localparam logic [W-1:0] EMPTY_WORD = {1'b0, {SIZE_W{1'b0}}, {PTR_W{1'b1}}};

  for (genvar b = 0; b < 2; b++) begin : g_slot
    logic [W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= EMPTY_WORD;
      end else if (ld_valid && (ld_sel == 1'(b))) begin
        word_q <= ld_word;
      end else if (upd_valid && (upd_sel == 1'(b))) begin
        word_q <= upd_word;
      end
    end
    assign words[b] = word_q;
  end

  // R1: a load shows up unchanged one cycle later
  assert_load_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> words[$past(ld_sel)] == $past(ld_word));
endmodule

// File: rtl/ep_buf_pick.sv
module ep_buf_pick #(
  parameter int SIZE_W = 14,
  parameter int PTR_W  = 17,
  parameter int MPL_W  = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0][SIZE_W+PTR_W:0] words,
  input  logic                       cur,
  input  logic                       is_ctrl,
  input  logic                       fixed_sel,
  input  logic                       need_room,
  input  logic [MPL_W-1:0]           max_pl,
  output logic                       pick_ok,
  output logic                       pick_sel
);
  localparam int W = 1 + SIZE_W + PTR_W;

  logic [1:0] usable;

  for (genvar b = 0; b < 2; b++) begin : g_chk
    logic             used_b;
    logic [SIZE_W-1:0] size_b;
    logic [PTR_W-1:0]  ptr_b;
    logic             alloc_b;
    logic             room_b;
    assign used_b  = words[b][W-1];
    assign size_b  = words[b][W-2 -: SIZE_W];
    assign ptr_b   = words[b][PTR_W-1:0];
    assign alloc_b = (ptr_b != {PTR_W{1'b1}});
    assign room_b  = (size_b >= SIZE_W'(max_pl));
    assign usable[b] = alloc_b && !used_b && (!need_room || room_b);
  end

  always_comb begin
    if (is_ctrl) begin
      pick_sel = fixed_sel;
      pick_ok  = usable[fixed_sel];
    end else if (usable[cur]) begin
      pick_sel = cur;
      pick_ok  = 1'b1;
    end else if (usable[~cur]) begin
      pick_sel = ~cur;
      pick_ok  = 1'b1;
    end else begin
      pick_sel = cur;
      pick_ok  = 1'b0;
    end
  end

  // R2: the current buffer is never passed over while it is still usable
  assert_prefer_current_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ctrl && usable[cur]) |-> (pick_ok && pick_sel == cur));
endmodule

// File: rtl/ep_hs_fsm.sv
module ep_hs_fsm
  import ep_hs_pkg::*;
#(
  parameter int SIZE_W = 14,
  parameter int PTR_W  = 17,
  parameter int MPL_W  = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tok_valid,
  input  logic [1:0]                 tok_kind,
  input  logic                       rx_valid,
  input  logic                       rx_crc_ok,
  input  logic                       rx_pid,
  input  logic [MPL_W-1:0]           rx_len,
  input  logic                       hs_valid,
  input  logic                       hs_ack,
  input  logic                       cfg_ctrl,
  input  logic                       cfg_dir_in,
  input  logic                       cfg_halt,
  input  logic                       cfg_disable,
  input  logic                       cfg_hs,
  input  logic [MPL_W-1:0]           cfg_max_pl,
  input  logic [1:0][SIZE_W+PTR_W:0] words,
  input  logic                       pick_ok,
  input  logic                       pick_sel,
  output logic                       cur,
  output logic                       need_room,
  output logic                       fixed_sel,
  output logic                       upd_valid,
  output logic                       upd_sel,
  output logic [SIZE_W+PTR_W:0]      upd_word,
  output logic                       ack_evt,
  output logic                       rep_valid,
  output logic [2:0]                 rep_code,
  output logic                       rep_sel,
  output logic [MPL_W-1:0]           rep_len,
  output logic [PTR_W-1:0]           rep_ptr,
  output logic                       rep_pid,
  output logic                       buf_done,
  output logic                       buf_done_sel
);
  localparam int W = 1 + SIZE_W + PTR_W;

  // ---- arithmetic helpers ----
  function automatic logic [SIZE_W-1:0] f_size(input logic [W-1:0] w);
    return w[W-2 -: SIZE_W];
  endfunction

  function automatic logic [PTR_W-1:0] f_ptr(input logic [W-1:0] w);
    return w[PTR_W-1:0];
  endfunction

  function automatic logic [MPL_W-1:0] f_in_len(input logic [MPL_W-1:0] mx,
                                               input logic [SIZE_W-1:0] sz);
    return (sz < SIZE_W'(mx)) ? MPL_W'(sz) : mx;
  endfunction

  function automatic logic f_fits(input logic [MPL_W-1:0] len,
                                  input logic [MPL_W-1:0] mx,
                                  input logic [SIZE_W-1:0] sz);
    return (len <= mx) && (SIZE_W'(len) <= sz);
  endfunction

  function automatic logic [W-1:0] f_advance(input logic [W-1:0] w,
                                             input logic [MPL_W-1:0] len,
                                             input logic done);
    return {done, f_size(w) - SIZE_W'(len), f_ptr(w) + PTR_W'(len)};
  endfunction

  // ---- state ----
  ep_st_e           st_q, st_n;
  logic             cur_q, cur_n;
  logic             tog_q, tog_n;
  logic             psel_q, psel_n;
  logic [MPL_W-1:0] plen_q, plen_n;
  logic             rv_q, rv_n;
  rep_e             rc_q, rc_n;
  logic             rs_q, rs_n;
  logic [MPL_W-1:0] rl_q, rl_n;
  logic [PTR_W-1:0] rp_q, rp_n;
  logic             rpid_q, rpid_n;
  logic             dn_q, dn_n;
  logic             dsel_q, dsel_n;

  // ---- named events ----
  tok_e        kind;
  logic        dir_ok;
  logic        tok_live;
  logic        data_take;
  logic [W-1:0] pend_w;
  logic [W-1:0] pick_w;
  logic [W-1:0] rx_next_w;
  logic         rx_full;
  logic [W-1:0] tx_next_w;
  logic         tx_empty;

  assign kind = tok_e'(tok_kind);

  always_comb begin
    if (cfg_ctrl) begin
      dir_ok = (kind != TK_PING) || cfg_hs;
    end else begin
      unique case (kind)
        TK_IN:   dir_ok = cfg_dir_in;
        TK_OUT:  dir_ok = !cfg_dir_in;
        TK_PING: dir_ok = !cfg_dir_in && cfg_hs;
        default: dir_ok = 1'b0;
      endcase
    end
  end

  assign tok_live  = tok_valid && dir_ok && !cfg_disable;
  assign data_take = rx_valid && (st_q == ST_RXDATA) && !tok_valid;
  assign ack_evt   = hs_valid && (st_q == ST_TXACK) && !tok_valid;
  assign need_room = (kind != TK_IN);
  assign fixed_sel = (kind == TK_IN);

  assign pend_w    = words[psel_q];
  assign pick_w    = words[pick_sel];
  assign rx_full   = (f_size(pend_w) - SIZE_W'(rx_len)) < SIZE_W'(cfg_max_pl);
  assign rx_next_w = f_advance(pend_w, rx_len, rx_full);
  assign tx_empty  = (f_size(pend_w) == SIZE_W'(plen_q));
  assign tx_next_w = f_advance(pend_w, plen_q, tx_empty);

  always_comb begin
    st_n = st_q;  cur_n = cur_q;  tog_n = tog_q;
    psel_n = psel_q;  plen_n = plen_q;
    rv_n = 1'b0;  rc_n = RP_NONE;  rs_n = rs_q;
    rl_n = '0;  rp_n = '0;  rpid_n = tog_q;
    dn_n = 1'b0;  dsel_n = dsel_q;
    upd_valid = 1'b0;  upd_sel = psel_q;  upd_word = pend_w;

    if (tok_valid) begin
      st_n = ST_IDLE;
      if (!tok_live) begin
        rv_n = 1'b1;  rc_n = RP_NONE;
      end else if (cfg_halt && kind != TK_SETUP) begin
        rv_n = 1'b1;  rc_n = RP_STALL;
      end else if (kind == TK_PING) begin
        rv_n = 1'b1;  rs_n = pick_sel;
        rc_n = pick_ok ? RP_ACK : RP_NAK;
      end else if (!pick_ok) begin
        rv_n = 1'b1;  rs_n = pick_sel;  rc_n = RP_NAK;
      end else if (kind == TK_IN) begin
        rv_n = 1'b1;  rc_n = RP_DATA;  rs_n = pick_sel;
        rl_n = f_in_len(cfg_max_pl, f_size(pick_w));
        rp_n = f_ptr(pick_w);
        psel_n = pick_sel;
        plen_n = f_in_len(cfg_max_pl, f_size(pick_w));
        st_n = ST_TXACK;
      end else begin
        psel_n = pick_sel;
        st_n = ST_RXDATA;
        if (kind == TK_SETUP) tog_n = 1'b0;
      end
    end else if (data_take) begin
      st_n = ST_IDLE;
      rv_n = 1'b1;  rs_n = psel_q;
      if (!rx_crc_ok) begin
        rc_n = RP_NONE;
      end else if (rx_pid != tog_q) begin
        rc_n = RP_ACK;
      end else if (!f_fits(rx_len, cfg_max_pl, f_size(pend_w))) begin
        rc_n = RP_NAK;
      end else begin
        upd_valid = 1'b1;
        upd_word  = rx_next_w;
        tog_n     = ~tog_q;
        rc_n      = (cfg_hs && rx_full) ? RP_NYET : RP_ACK;
        if (rx_full) begin
          dn_n = 1'b1;  dsel_n = psel_q;
          if (!cfg_ctrl) cur_n = ~psel_q;
        end
      end
    end else if (ack_evt) begin
      st_n = ST_IDLE;
      if (hs_ack) begin
        upd_valid = 1'b1;
        upd_word  = tx_next_w;
        tog_n     = ~tog_q;
        if (tx_empty) begin
          dn_n = 1'b1;  dsel_n = psel_q;
          if (!cfg_ctrl) cur_n = ~psel_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cur_q <= 1'b0;  tog_q <= 1'b0;
      psel_q <= 1'b0;  plen_q <= '0;
      rv_q <= 1'b0;  rc_q <= RP_NONE;  rs_q <= 1'b0;
      rl_q <= '0;  rp_q <= '0;  rpid_q <= 1'b0;
      dn_q <= 1'b0;  dsel_q <= 1'b0;
    end else begin
      st_q <= st_n;  cur_q <= cur_n;  tog_q <= tog_n;
      psel_q <= psel_n;  plen_q <= plen_n;
      rv_q <= rv_n;  rc_q <= rc_n;  rs_q <= rs_n;
      rl_q <= rl_n;  rp_q <= rp_n;  rpid_q <= rpid_n;
      dn_q <= dn_n;  dsel_q <= dsel_n;
    end
  end

  assign cur          = cur_q;
  assign rep_valid    = rv_q;
  assign rep_code     = rc_q;
  assign rep_sel      = rs_q;
  assign rep_len      = rl_q;
  assign rep_ptr      = rp_q;
  assign rep_pid      = rpid_q;
  assign buf_done     = dn_q;
  assign buf_done_sel = dsel_q;

  // R5: halted endpoint answers live IN/OUT/PING with STALL
  assert_stall_on_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_live && cfg_halt && kind != TK_SETUP) |=> (rep_valid && rep_code == RP_STALL));

  // R4: no usable buffer gives NAK right after the token
  assert_nak_when_starved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_live && !cfg_halt && kind != TK_PING && !pick_ok) |=> (rep_valid && rep_code == RP_NAK));

  // R12: CRC-damaged data packet draws no handshake
  assert_silent_on_crc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && !rx_crc_ok) |=> (rep_valid && rep_code == RP_NONE));

  // R13: disabled endpoint stays silent
  assert_quiet_when_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && cfg_disable) |=> (rep_valid && rep_code == RP_NONE && !buf_done));

  // R8: IN length never exceeds the max payload
  assert_in_len_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_code == RP_DATA) |-> (rep_len <= cfg_max_pl));
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl #(
  parameter int SIZE_W = 14,
  parameter int PTR_W  = 17,
  parameter int MPL_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tok_valid,
  input  logic [1:0]               tok_kind,
  input  logic                     rx_valid,
  input  logic                     rx_crc_ok,
  input  logic                     rx_pid,
  input  logic [MPL_W-1:0]         rx_len,
  input  logic                     hs_valid,
  input  logic                     hs_ack,
  input  logic                     cfg_ctrl,
  input  logic                     cfg_dir_in,
  input  logic                     cfg_halt,
  input  logic                     cfg_disable,
  input  logic                     cfg_hs,
  input  logic [MPL_W-1:0]         cfg_max_pl,
  input  logic                     dsc_ld,
  input  logic                     dsc_ld_sel,
  input  logic [SIZE_W+PTR_W:0]    dsc_ld_word,
  output logic                     rep_valid,
  output logic [2:0]               rep_code,
  output logic                     rep_sel,
  output logic [MPL_W-1:0]         rep_len,
  output logic [PTR_W-1:0]         rep_ptr,
  output logic                     rep_pid,
  output logic [SIZE_W+PTR_W:0]    dsc0_word,
  output logic [SIZE_W+PTR_W:0]    dsc1_word,
  output logic                     buf_done,
  output logic                     buf_done_sel
);
  localparam int W = 1 + SIZE_W + PTR_W;

  logic [1:0][W-1:0] words;
  logic              cur, need_room, fixed_sel;
  logic              pick_ok, pick_sel;
  logic              upd_valid, upd_sel;
  logic [W-1:0]      upd_word;
  logic              ack_evt;

  ep_desc_bank #(.SIZE_W(SIZE_W), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(dsc_ld), .ld_sel(dsc_ld_sel), .ld_word(dsc_ld_word),
    .upd_valid(upd_valid), .upd_sel(upd_sel), .upd_word(upd_word),
    .words(words)
  );

  ep_buf_pick #(.SIZE_W(SIZE_W), .PTR_W(PTR_W), .MPL_W(MPL_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .words(words), .cur(cur), .is_ctrl(cfg_ctrl), .fixed_sel(fixed_sel),
    .need_room(need_room), .max_pl(cfg_max_pl),
    .pick_ok(pick_ok), .pick_sel(pick_sel)
  );

  ep_hs_fsm #(.SIZE_W(SIZE_W), .PTR_W(PTR_W), .MPL_W(MPL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_kind(tok_kind),
    .rx_valid(rx_valid), .rx_crc_ok(rx_crc_ok), .rx_pid(rx_pid), .rx_len(rx_len),
    .hs_valid(hs_valid), .hs_ack(hs_ack),
    .cfg_ctrl(cfg_ctrl), .cfg_dir_in(cfg_dir_in), .cfg_halt(cfg_halt),
    .cfg_disable(cfg_disable), .cfg_hs(cfg_hs), .cfg_max_pl(cfg_max_pl),
    .words(words), .pick_ok(pick_ok), .pick_sel(pick_sel),
    .cur(cur), .need_room(need_room), .fixed_sel(fixed_sel),
    .upd_valid(upd_valid), .upd_sel(upd_sel), .upd_word(upd_word),
    .ack_evt(ack_evt),
    .rep_valid(rep_valid), .rep_code(rep_code), .rep_sel(rep_sel),
    .rep_len(rep_len), .rep_ptr(rep_ptr), .rep_pid(rep_pid),
    .buf_done(buf_done), .buf_done_sel(buf_done_sel)
  );

  assign dsc0_word = words[0];
  assign dsc1_word = words[1];

  // R3: a completion event leaves the named buffer marked used
  assert_done_marks_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && !$past(dsc_ld && dsc_ld_sel == buf_done_sel)) |-> words[buf_done_sel][W-1]);

  // R9: a timed-out IN leaves both descriptors alone
  assert_timeout_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !hs_ack && !dsc_ld) |=> $stable(words));
endmodule

// File: tb/ep_hs_ctrl_tb.sv
module ep_hs_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE_W = 14;
  localparam int PTR_W  = 17;
  localparam int MPL_W  = 11;
  localparam int W = 1 + SIZE_W + PTR_W;

  localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2, K_PING = 2'd3;
  localparam logic [2:0] C_NONE = 3'd0, C_ACK = 3'd1, C_NAK = 3'd2,
                         C_NYET = 3'd3, C_STALL = 3'd4, C_DATA = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 0; logic [1:0] tok_kind = 0;
  logic rx_valid = 0, rx_crc_ok = 0, rx_pid = 0; logic [MPL_W-1:0] rx_len = 0;
  logic hs_valid = 0, hs_ack = 0;
  logic cfg_ctrl = 0, cfg_dir_in = 0, cfg_halt = 0, cfg_disable = 0, cfg_hs = 0;
  logic [MPL_W-1:0] cfg_max_pl = 11'd64;
  logic dsc_ld = 0, dsc_ld_sel = 0; logic [W-1:0] dsc_ld_word = 0;
  logic rep_valid, rep_sel, rep_pid, buf_done, buf_done_sel;
  logic [2:0] rep_code;
  logic [MPL_W-1:0] rep_len;
  logic [PTR_W-1:0] rep_ptr;
  logic [W-1:0] dsc0_word, dsc1_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_hs_ctrl #(.SIZE_W(SIZE_W), .PTR_W(PTR_W), .MPL_W(MPL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .rx_valid(rx_valid), .rx_crc_ok(rx_crc_ok), .rx_pid(rx_pid), .rx_len(rx_len),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .cfg_ctrl(cfg_ctrl), .cfg_dir_in(cfg_dir_in),
    .cfg_halt(cfg_halt), .cfg_disable(cfg_disable), .cfg_hs(cfg_hs), .cfg_max_pl(cfg_max_pl),
    .dsc_ld(dsc_ld), .dsc_ld_sel(dsc_ld_sel), .dsc_ld_word(dsc_ld_word),
    .rep_valid(rep_valid), .rep_code(rep_code), .rep_sel(rep_sel), .rep_len(rep_len),
    .rep_ptr(rep_ptr), .rep_pid(rep_pid), .dsc0_word(dsc0_word), .dsc1_word(dsc1_word),
    .buf_done(buf_done), .buf_done_sel(buf_done_sel)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // scoreboard queues (one entry per expected reply)
  logic [2:0]       q_code[$];
  logic             q_sel[$];
  logic [MPL_W-1:0] q_len[$];
  logic [PTR_W-1:0] q_ptr[$];
  logic             q_pid[$];
  string            q_req[$];

  function automatic logic [W-1:0] mkw(input logic u, input int sz, input int p);
    return {u, SIZE_W'(sz), PTR_W'(p)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_rep(input logic [2:0] c, input logic s, input int l,
                            input int p, input logic pid, input string req);
    q_code.push_back(c); q_sel.push_back(s); q_len.push_back(MPL_W'(l));
    q_ptr.push_back(PTR_W'(p)); q_pid.push_back(pid); q_req.push_back(req);
  endtask

  // monitor: pop and compare each reply as it appears
  always @(negedge clk) begin
    if (rst_n && rep_valid) begin
      if (q_code.size() == 0) begin
        chk("R?", "unexpected reply code", 32'(rep_code), 32'hFFFF_FFFF);
      end else begin
        logic [2:0] c; logic s; logic [MPL_W-1:0] l; logic [PTR_W-1:0] p; logic d; string r;
        c = q_code.pop_front(); s = q_sel.pop_front(); l = q_len.pop_front();
        p = q_ptr.pop_front(); d = q_pid.pop_front(); r = q_req.pop_front();
        chk(r, "reply code", 32'(rep_code), 32'(c));
        if (c == C_DATA) begin
          chk(r, "data buffer", 32'(rep_sel), 32'(s));
          chk(r, "data length", 32'(rep_len), 32'(l));
          chk(r, "data address", 32'(rep_ptr), 32'(p));
          chk(r, "data pid", 32'(rep_pid), 32'(d));
        end
      end
    end
  end

  task automatic tok(input logic [1:0] k);
    @(negedge clk); tok_valid = 1'b1; tok_kind = k;
    @(negedge clk); tok_valid = 1'b0;
  endtask

  task automatic pkt(input logic pid, input int len, input logic crc);
    @(negedge clk); rx_valid = 1'b1; rx_pid = pid; rx_len = MPL_W'(len); rx_crc_ok = crc;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic hsk(input logic a);
    @(negedge clk); hs_valid = 1'b1; hs_ack = a;
    @(negedge clk); hs_valid = 1'b0;
  endtask

  task automatic load(input logic s, input logic [W-1:0] w);
    @(negedge clk); dsc_ld = 1'b1; dsc_ld_sel = s; dsc_ld_word = w;
    @(negedge clk); dsc_ld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cfg_ctrl = 0; cfg_dir_in = 0; cfg_halt = 0; cfg_disable = 0; cfg_hs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reply idle after reset", 32'(rep_valid), 0);
    chk("R1", "buffer 0 after reset", dsc0_word, mkw(0, 0, 32'h1FFFF));
    chk("R1", "buffer 1 after reset", dsc1_word, mkw(0, 0, 32'h1FFFF));
    chk("R1", "no done after reset", 32'(buf_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // ---------------- OUT endpoint ----------------
    do_reset();
    expect_rep(C_NAK, 0, 0, 0, 0, "R4 out starved");
    tok(K_OUT);

    load(0, mkw(0, 128, 'h100));
    load(1, mkw(0, 64, 'h400));
    chk("R1", "buffer 0 loaded", dsc0_word, mkw(0, 128, 'h100));

    tok(K_OUT);
    expect_rep(C_ACK, 0, 0, 0, 0, "R7 fs ack");
    pkt(0, 64, 1);
    chk("R2", "buffer 0 advanced first", dsc0_word, mkw(0, 64, 'h140));
    chk("R2", "buffer 1 untouched", dsc1_word, mkw(0, 64, 'h400));

    tok(K_OUT);
    expect_rep(C_ACK, 0, 0, 0, 0, "R3 fs ack on fill");
    pkt(1, 64, 1);
    chk("R3", "buffer 0 used", dsc0_word, mkw(1, 0, 'h180));
    chk("R3", "done pulse", 32'(buf_done), 1);
    chk("R3", "done names buffer 0", 32'(buf_done_sel), 0);

    tok(K_OUT);
    expect_rep(C_ACK, 0, 0, 0, 0, "R6 pid mismatch");
    pkt(1, 16, 1);
    chk("R6", "buffer 1 kept on mismatch", dsc1_word, mkw(0, 64, 'h400));

    tok(K_OUT);
    expect_rep(C_NONE, 0, 0, 0, 0, "R12 crc error");
    pkt(0, 16, 0);
    chk("R12", "buffer 1 kept on crc error", dsc1_word, mkw(0, 64, 'h400));

    cfg_hs = 1;
    tok(K_OUT);
    expect_rep(C_NYET, 0, 0, 0, 0, "R7 hs nyet");
    pkt(0, 64, 1);
    chk("R3", "buffer 1 used", dsc1_word, mkw(1, 0, 'h440));
    chk("R3", "done names buffer 1", 32'(buf_done_sel), 1);

    expect_rep(C_NAK, 0, 0, 0, 0, "R4 out both used");
    tok(K_OUT);
    expect_rep(C_NAK, 0, 0, 0, 0, "R14 ping no room");
    tok(K_PING);

    load(0, mkw(0, 128, 'h200));
    expect_rep(C_ACK, 0, 0, 0, 0, "R14 ping room");
    tok(K_PING);

    tok(K_OUT);
    expect_rep(C_NAK, 0, 0, 0, 0, "R12 overflow");
    pkt(1, 100, 1);
    chk("R12", "buffer 0 kept on overflow", dsc0_word, mkw(0, 128, 'h200));

    tok(K_OUT);
    expect_rep(C_ACK, 0, 0, 0, 0, "R7 hs ack with room");
    pkt(1, 10, 1);
    chk("R11", "short packet advanced", dsc0_word, mkw(0, 118, 'h20A));

    tok(K_OUT);
    expect_rep(C_NYET, 0, 0, 0, 0, "R8 below max counts full");
    pkt(0, 60, 1);
    chk("R8", "remaining 58 marks used", dsc0_word, mkw(1, 58, 'h246));

    load(0, mkw(0, 64, 'h300));
    cfg_halt = 1;
    expect_rep(C_STALL, 0, 0, 0, 0, "R5 out halt");
    tok(K_OUT);
    expect_rep(C_STALL, 0, 0, 0, 0, "R5 ping halt");
    tok(K_PING);
    cfg_halt = 0;

    cfg_disable = 1;
    expect_rep(C_NONE, 0, 0, 0, 0, "R13 disabled");
    tok(K_OUT);
    cfg_disable = 0;
    cfg_hs = 0;
    expect_rep(C_NONE, 0, 0, 0, 0, "R13 fs ping");
    tok(K_PING);
    expect_rep(C_NONE, 0, 0, 0, 0, "R13 in on out ep");
    tok(K_IN);
    expect_rep(C_NONE, 0, 0, 0, 0, "R13 setup on bulk");
    tok(K_SETUP);
    chk("R13", "buffer 0 kept when ignored", dsc0_word, mkw(0, 64, 'h300));

    // ---------------- IN endpoint ----------------
    do_reset();
    cfg_dir_in = 1;
    load(0, mkw(0, 100, 'h10));
    expect_rep(C_DATA, 0, 64, 'h10, 0, "R8 in clipped to max");
    tok(K_IN);
    hsk(0);
    chk("R9", "timeout keeps buffer", dsc0_word, mkw(0, 100, 'h10));
    expect_rep(C_DATA, 0, 64, 'h10, 0, "R11 retry same pid");
    tok(K_IN);
    hsk(1);
    chk("R9", "ack advances buffer", dsc0_word, mkw(0, 36, 'h50));
    expect_rep(C_DATA, 0, 36, 'h50, 1, "R8 in remaining size");
    tok(K_IN);
    hsk(1);
    chk("R3", "in buffer drained", dsc0_word, mkw(1, 0, 'h74));
    chk("R3", "in done pulse", 32'(buf_done), 1);
    expect_rep(C_NAK, 0, 0, 0, 0, "R4 in starved");
    tok(K_IN);

    load(1, mkw(0, 8, 'h800));
    expect_rep(C_DATA, 1, 8, 'h800, 0, "R2 alternate to buffer 1");
    tok(K_IN);
    hsk(1);
    load(1, mkw(0, 16, 'h900));
    expect_rep(C_DATA, 1, 16, 'h900, 1, "R2 skip used buffer 0");
    tok(K_IN);
    cfg_halt = 1;
    expect_rep(C_STALL, 0, 0, 0, 0, "R5 in halt");
    tok(K_IN);
    chk("R9", "preempted in keeps buffer", dsc1_word, mkw(0, 16, 'h900));
    cfg_halt = 0;

    // ---------------- control endpoint ----------------
    do_reset();
    cfg_ctrl = 1;
    load(0, mkw(0, 64, 'h0));
    load(1, mkw(0, 64, 'h80));
    tok(K_SETUP);
    expect_rep(C_ACK, 0, 0, 0, 0, "R10 setup data0");
    pkt(0, 8, 1);
    chk("R10", "setup lands in buffer 0", dsc0_word, mkw(1, 56, 'h8));
    expect_rep(C_DATA, 1, 64, 'h80, 1, "R10 in from buffer 1");
    tok(K_IN);
    hsk(1);
    chk("R10", "buffer 1 drained", dsc1_word, mkw(1, 0, 'hC0));
    expect_rep(C_NAK, 0, 0, 0, 0, "R10 out only buffer 0");
    tok(K_OUT);

    repeat (3) @(negedge clk);
    chk("R4", "all expected replies seen", 32'(q_code.size()), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule